// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block sits between an 8-bit host bus and three independent down-counting timer channels. The host sees four byte addresses. Addresses 0, 1 and 2 are the data ports of the three channels, and address 3 is the control register. Control words choose a channel's operating mode, its BCD flag and how its 16-bit count is moved across the 8-bit bus: as the low byte only, as the high byte only, or as a low/high byte pair.

The block turns data-port writes into a complete 16-bit count and a one-cycle load strobe for the addressed channel. For reads it steers the channel's live count, or a frozen snapshot of it, back onto the bus. Snapshots are taken by a per-channel latch command or by a multi-channel read-back command. The read-back command can also capture a status byte that describes the channel's output pin, its null-count flag and its programming.

The counting logic is outside this block. Each channel returns its live count, its output level and its null-count flag to the block. Read data is combinational from the address and the sequencer state. A read or write takes effect on the clock edge where its strobe is high.

Top module: `tmr_busif`

## Requirements
- R1: After reset every channel is in low-then-high two-byte format with mode 0 and BCD 0, and holds no latched count or status. All `ch_count` outputs are 0 and `ch_load` is low.
- R2: A control-register write with bits 7:6 equal to 0, 1 or 2 and bits 5:4 non-zero programs that channel. Bits 5:4 become its byte format (01 low only, 10 high only, 11 low then high), bits 3:1 drive `ch_mode` and bit 0 drives `ch_bcd`. Both byte sequencers restart at the low byte, any held count or status is dropped, and no load strobe occurs.
- R3: In two-byte format the first data write supplies the low byte and the second supplies the high byte. Only the second write raises that channel's `ch_load` bit, for one cycle in the clock period after the write edge, with the assembled value on `ch_count`.
- R4: In low-only format a written byte loads as {0x00, byte}, and in high-only format as {byte, 0x00}. Every such write gives a load strobe.
- R5: With nothing latched, a data-port read returns the live count: the low byte in low-only format, the high byte in high-only format, and low then high on alternate reads in two-byte format.
- R6: A control word with bits 5:4 = 00 freezes the selected channel's live count. Reads return the frozen value until it has been read completely in the channel's format, after which reads return the live count again.
- R7: A count-latch request for a channel that still holds an unread latched count is ignored.
- R8: A control word with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count of each selected channel, and bit 4 = 0 latches its status.
- R9: The status byte holds OUT in bit 7, null count in bit 6, the byte format in bits 5:4, the mode in bits 3:1 and BCD in bit 0, sampled when the command is taken. While a status is held, the next read of that channel returns it, and later reads return the latched or live count.
- R10: A status-latch request for a channel whose status has not yet been read is ignored.
- R11: Reads of the control register return 0x00 and change no channel's state.
- R12: `rdata` shows the byte for the current address and sequencer state in the same cycle. The sequencer advances on the clock edge where `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| addr | input | 2 | 0–2 channel data ports, 3 control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ch_mode | output | 9 | Per-channel mode, 3 bits per channel |
| ch_bcd | output | 3 | Per-channel BCD select |
| ch_count | output | 48 | Per-channel count value to load, 16 bits per channel |
| ch_load | output | 3 | Per-channel one-cycle load strobe |
| ch_live | input | 48 | Per-channel live count from the counter |
| ch_out | input | 3 | Per-channel OUT level |
| ch_null | input | 3 | Per-channel null-count flag |

## Verification
Directed sequences run each byte format in turn, so that a swapped low/high byte or a load strobe raised on the first half of a pair gives a wrong count or a wrong strobe. Latched reads are run while the live count changes between the two bytes. This separates a frozen snapshot from a live pass-through, and a second latch command before the first is drained shows whether repeated latches are ignored. Read-back commands combine count and status with different channel masks, and OUT and null-count change between command and read. This checks the status byte layout, the order in which status and count are returned, and the time at which the status is sampled. A long random mix of programming, data writes, reads, latches and live-count changes then covers sequencer interleavings that the directed cases do not reach.

// File: rtl/tmr_busif_pkg.sv
package tmr_busif_pkg;

   // Byte-access format carried in control word bits 5:4
   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD  = 2'b11
   } acc_e;

   localparam logic [1:0] CTRL_ADDR    = 2'd3;
   localparam logic [1:0] SEL_READBACK = 2'd3;

   // Status byte: OUT, null count, format, mode, BCD (MSB to LSB)
   typedef struct packed {
      logic       out;
      logic       nul;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } status_t;

endpackage

// File: rtl/tmr_ctl_dec.sv
module tmr_ctl_dec
   import tmr_busif_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic           wr_en,
   input  logic [1:0]     addr,
   input  logic [7:1]     ctl,
   output logic [NCH-1:0] prog,
   output logic [NCH-1:0] cnt_lat,
   output logic [NCH-1:0] sts_lat
);

   logic       ctl_wr;
   logic [1:0] sel;
   logic [1:0] acc;

   assign ctl_wr = wr_en && (addr == CTRL_ADDR);
   assign sel    = ctl[7:6];
   assign acc    = ctl[5:4];

   always_comb begin
      prog    = '0;
      cnt_lat = '0;
      sts_lat = '0;
      if (ctl_wr) begin
         for (int i = 0; i < NCH; i++) begin
            if (sel == 2'(i)) begin
               if (acc == ACC_LATCH) cnt_lat[i] = 1'b1;
               else                  prog[i]    = 1'b1;
            end else if (sel == SEL_READBACK && ctl[i+1]) begin
               cnt_lat[i] = !ctl[5];
               sts_lat[i] = !ctl[4];
            end
         end
      end
   end

endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
   import tmr_busif_pkg::*;
#(
   parameter  int BYTE_W = 8,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output acc_e              acc,
   output logic [2:0]        mode,
   output logic              bcd,
   output logic [CNT_W-1:0]  count,
   output logic              load
);

   logic [BYTE_W-1:0] lo_byte;
   logic              hi_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc     <= ACC_WORD;
         mode    <= 3'd0;
         bcd     <= 1'b0;
         count   <= '0;
         load    <= 1'b0;
         lo_byte <= '0;
         hi_next <= 1'b0;
      end else begin
         load <= 1'b0;
         if (prog) begin
            acc     <= acc_e'(wdata[5:4]);
            mode    <= wdata[3:1];
            bcd     <= wdata[0];
            hi_next <= 1'b0;
         end else if (wr) begin
            case (acc)
               ACC_LO: begin
                  count <= {{BYTE_W{1'b0}}, wdata};
                  load  <= 1'b1;
               end
               ACC_HI: begin
                  count <= {wdata, {BYTE_W{1'b0}}};
                  load  <= 1'b1;
               end
               ACC_WORD: begin
                  if (!hi_next) begin
                     lo_byte <= wdata;
                     hi_next <= 1'b1;
                  end else begin
                     count   <= {wdata, lo_byte};
                     load    <= 1'b1;
                     hi_next <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tmr_rd_seq.sv
module tmr_rd_seq
   import tmr_busif_pkg::*;
#(
   parameter  int BYTE_W       = 8,
   parameter  bit STS_SNAPSHOT = 1'b1,
   localparam int CNT_W        = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              cnt_lat,
   input  logic              sts_lat,
   input  logic              rd,
   input  acc_e              acc,
   input  logic [2:0]        mode,
   input  logic              bcd,
   input  logic [CNT_W-1:0]  live,
   input  logic              out,
   input  logic              nul,
   output logic [BYTE_W-1:0] rbyte
);

   logic             cnt_held;
   logic             sts_held;
   logic             hi_next;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] src;
   status_t          sts_now;
   status_t          sts_rd;

   assign sts_now = {out, nul, acc, mode, bcd};

   generate
      if (STS_SNAPSHOT) begin : g_snap
         status_t sts_val;
         always_ff @(posedge clk) begin
            if (!rst_n)                                 sts_val <= '0;
            else if (!prog && sts_lat && !sts_held)     sts_val <= sts_now;
         end
         assign sts_rd = sts_val;
      end else begin : g_live
         assign sts_rd = sts_now;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_held <= 1'b0;
         sts_held <= 1'b0;
         hi_next  <= 1'b0;
         cnt_val  <= '0;
      end else if (prog) begin
         cnt_held <= 1'b0;
         sts_held <= 1'b0;
         hi_next  <= 1'b0;
      end else begin
         if (rd) begin
            if (sts_held) begin
               sts_held <= 1'b0;
            end else if (acc == ACC_WORD) begin
               hi_next <= !hi_next;
               if (hi_next) cnt_held <= 1'b0;
            end else begin
               cnt_held <= 1'b0;
            end
         end
         if (cnt_lat && !cnt_held) begin
            cnt_held <= 1'b1;
            cnt_val  <= live;
         end
         if (sts_lat && !sts_held) sts_held <= 1'b1;
      end
   end

   assign src = cnt_held ? cnt_val : live;

   always_comb begin
      if (sts_held) begin
         rbyte = BYTE_W'(sts_rd);
      end else begin
         case (acc)
            ACC_HI:   rbyte = src[CNT_W-1:BYTE_W];
            ACC_WORD: rbyte = hi_next ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            default:  rbyte = src[BYTE_W-1:0];
         endcase
      end
   end

endmodule

// File: rtl/tmr_busif.sv
module tmr_busif
   import tmr_busif_pkg::*;
#(
   parameter  int NCH          = 3,
   parameter  int BYTE_W       = 8,
   parameter  bit STS_SNAPSHOT = 1'b1,
   localparam int CNT_W        = 2 * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [1:0]           addr,
   input  logic [BYTE_W-1:0]    wdata,
   output logic [BYTE_W-1:0]    rdata,
   output logic [NCH*3-1:0]     ch_mode,
   output logic [NCH-1:0]       ch_bcd,
   output logic [NCH*CNT_W-1:0] ch_count,
   output logic [NCH-1:0]       ch_load,
   input  logic [NCH*CNT_W-1:0] ch_live,
   input  logic [NCH-1:0]       ch_out,
   input  logic [NCH-1:0]       ch_null
);

   generate
      if (NCH < 1 || NCH > 3) begin : g_bad_nch
         $error("tmr_busif: NCH must be 1 to 3");
      end
      if (BYTE_W != 8) begin : g_bad_bw
         $error("tmr_busif: control and status layout needs BYTE_W == 8");
      end
   endgenerate

   logic [NCH-1:0]    prog;
   logic [NCH-1:0]    cnt_lat;
   logic [NCH-1:0]    sts_lat;
   logic [BYTE_W-1:0] rbyte [NCH];

   tmr_ctl_dec #(.NCH(NCH)) u_dec (
      .wr_en   (wr_en),
      .addr    (addr),
      .ctl     (wdata[7:1]),
      .prog    (prog),
      .cnt_lat (cnt_lat),
      .sts_lat (sts_lat)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         acc_e       acc;
         logic [2:0] mode;
         logic       bcd;
         logic       wr_hit;
         logic       rd_hit;

         assign wr_hit = wr_en && (addr == 2'(g));
         assign rd_hit = rd_en && (addr == 2'(g));

         tmr_wr_seq #(.BYTE_W(BYTE_W)) u_wr (
            .clk   (clk),
            .rst_n (rst_n),
            .prog  (prog[g]),
            .wr    (wr_hit),
            .wdata (wdata),
            .acc   (acc),
            .mode  (mode),
            .bcd   (bcd),
            .count (ch_count[g*CNT_W +: CNT_W]),
            .load  (ch_load[g])
         );

         tmr_rd_seq #(.BYTE_W(BYTE_W), .STS_SNAPSHOT(STS_SNAPSHOT)) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .prog    (prog[g]),
            .cnt_lat (cnt_lat[g]),
            .sts_lat (sts_lat[g]),
            .rd      (rd_hit),
            .acc     (acc),
            .mode    (mode),
            .bcd     (bcd),
            .live    (ch_live[g*CNT_W +: CNT_W]),
            .out     (ch_out[g]),
            .nul     (ch_null[g]),
            .rbyte   (rbyte[g])
         );

         assign ch_mode[g*3 +: 3] = mode;
         assign ch_bcd[g]         = bcd;
      end
   endgenerate

   // Control register and unused channel slots read as zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr == 2'(i)) rdata = rbyte[i];
      end
   end

endmodule

// File: rtl/tmr_busif_chk.sv
module tmr_busif_chk #(
   parameter  int NCH    = 3,
   parameter  int BYTE_W = 8,
   localparam int CNT_W  = 2 * BYTE_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rd_en,
   input logic                 wr_en,
   input logic [1:0]           addr,
   input logic [BYTE_W-1:0]    rdata,
   input logic [NCH*3-1:0]     ch_mode,
   input logic [NCH-1:0]       ch_bcd,
   input logic [NCH*CNT_W-1:0] ch_count,
   input logic [NCH-1:0]       ch_load
);

   AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd3) |-> (rdata == '0)); // R11

   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load)); // R3

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chk
         AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_load[g] |-> $past(wr_en && addr == 2'(g))); // R3

         AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_load[g] |-> $stable(ch_count[g*CNT_W +: CNT_W])); // R4

         AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !($stable(ch_mode[g*3 +: 3]) && $stable(ch_bcd[g]))
               |-> $past(wr_en && addr == 2'd3)); // R2

         AST_NO_LOAD_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && addr == 2'd3) |-> !ch_load[g]); // R2
      end
   endgenerate

endmodule

bind tmr_busif tmr_busif_chk #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .rdata    (rdata),
   .ch_mode  (ch_mode),
   .ch_bcd   (ch_bcd),
   .ch_count (ch_count),
   .ch_load  (ch_load)
);

// File: tb/tmr_busif_tb.sv
module tmr_busif_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [7:0]  wdata = 8'd0;
   logic [7:0]  rdata;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;
   logic [47:0] ch_count;
   logic [2:0]  ch_load;

   // Reference model state
   logic [15:0] live  [3];
   logic        m_out [3];
   logic        m_nul [3];
   logic [1:0]  m_fmt [3];
   logic [2:0]  m_mode[3];
   logic        m_bcd [3];
   logic        m_wptr[3];
   logic        m_rptr[3];
   logic [7:0]  m_lo  [3];
   logic        m_ch  [3];
   logic [15:0] m_cv  [3];
   logic        m_sh  [3];
   logic [7:0]  m_sv  [3];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   tmr_busif u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .ch_mode  (ch_mode),
      .ch_bcd   (ch_bcd),
      .ch_count (ch_count),
      .ch_load  (ch_load),
      .ch_live  ({live[2], live[1], live[0]}),
      .ch_out   ({m_out[2], m_out[1], m_out[0]}),
      .ch_null  ({m_nul[2], m_nul[1], m_nul[0]})
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_status(input int c);
      return {m_out[c], m_nul[c], m_fmt[c], m_mode[c], m_bcd[c]};
   endfunction

   function automatic void model_latch(input int c, input bit cnt, input bit sts);
      if (cnt && !m_ch[c]) begin m_ch[c] = 1'b1; m_cv[c] = live[c]; end
      if (sts && !m_sh[c]) begin m_sh[c] = 1'b1; m_sv[c] = exp_status(c); end
   endfunction

   function automatic void model_ctrl(input logic [7:0] w);
      int sel = int'(w[7:6]);
      if (sel < 3) begin
         if (w[5:4] == 2'b00) model_latch(sel, 1'b1, 1'b0);
         else begin
            m_fmt[sel] = w[5:4]; m_mode[sel] = w[3:1]; m_bcd[sel] = w[0];
            m_wptr[sel] = 0; m_rptr[sel] = 0; m_ch[sel] = 0; m_sh[sel] = 0;
         end
      end else begin
         for (int c = 0; c < 3; c++)
            if (w[c+1]) model_latch(c, !w[5], !w[4]);
      end
   endfunction

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      logic        exp_ld  = 1'b0;
      logic [15:0] exp_cnt = '0;
      string       tag     = "R2";
      int          c       = int'(a);
      if (a == 2'd3) model_ctrl(d);
      else begin
         tag = (m_fmt[c] == 2'b11) ? "R3" : "R4";
         case (m_fmt[c])
            2'b01: begin exp_ld = 1'b1; exp_cnt = {8'h00, d}; end
            2'b10: begin exp_ld = 1'b1; exp_cnt = {d, 8'h00}; end
            default: begin
               if (!m_wptr[c]) begin m_lo[c] = d; m_wptr[c] = 1'b1; end
               else begin exp_ld = 1'b1; exp_cnt = {d, m_lo[c]}; m_wptr[c] = 1'b0; end
            end
         endcase
      end
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      if (a == 2'd3) begin
         chk(ch_load == 3'b000, "R2", 32'(ch_load), 32'd0);
         for (int k = 0; k < 3; k++)
            chk(ch_mode[k*3 +: 3] == m_mode[k] && ch_bcd[k] == m_bcd[k], "R2",
                {ch_mode[k*3 +: 3], ch_bcd[k]}, {m_mode[k], m_bcd[k]});
      end else begin
         chk(ch_load == (exp_ld ? (3'b001 << a) : 3'b000), tag, 32'(ch_load),
             exp_ld ? 32'(3'b001 << a) : 32'd0);
         if (exp_ld) chk(ch_count[c*16 +: 16] == exp_cnt, tag, 32'(ch_count[c*16 +: 16]), 32'(exp_cnt));
      end
   endtask

   task automatic bus_rd(input logic [1:0] a, input string tag_in = "");
      logic [7:0]  exp;
      logic [15:0] src;
      string       tag;
      int          c = int'(a);
      if (a == 2'd3) begin exp = 8'h00; tag = "R11"; end
      else if (m_sh[c]) begin exp = m_sv[c]; m_sh[c] = 1'b0; tag = "R9"; end
      else begin
         src = m_ch[c] ? m_cv[c] : live[c];
         tag = m_ch[c] ? "R6" : "R5";
         case (m_fmt[c])
            2'b01: begin exp = src[7:0]; m_ch[c] = 1'b0; end
            2'b10: begin exp = src[15:8]; m_ch[c] = 1'b0; end
            default: begin
               exp = m_rptr[c] ? src[15:8] : src[7:0];
               if (m_rptr[c]) m_ch[c] = 1'b0;
               m_rptr[c] = !m_rptr[c];
            end
         endcase
      end
      if (tag_in != "") tag = tag_in;
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 chk(rdata == exp, tag, 32'(rdata), 32'(exp));
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end

   initial begin
      for (int c = 0; c < 3; c++) begin
         live[c] = 16'h0000; m_out[c] = 0; m_nul[c] = 0;
         m_fmt[c] = 2'b11; m_mode[c] = 0; m_bcd[c] = 0;
         m_wptr[c] = 0; m_rptr[c] = 0; m_lo[c] = 0;
         m_ch[c] = 0; m_cv[c] = 0; m_sh[c] = 0; m_sv[c] = 0;
      end
      void'($urandom(32'h00C0FFEE));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(ch_load == 3'b000, "R1", 32'(ch_load), 0);
      chk(ch_count == '0, "R1", ch_count[31:0], 0);
      chk(ch_mode == '0 && ch_bcd == '0, "R1", {ch_mode, ch_bcd}, 0);
      live[0] = 16'hA55A;
      bus_rd(2'd0, "R1");
      bus_rd(2'd0, "R1");
      bus_rd(2'd3);

      // R3 two-byte write, R4 single-byte formats
      bus_wr(2'd3, 8'h36);
      bus_wr(2'd0, 8'h34);
      bus_wr(2'd0, 8'h12);
      bus_wr(2'd3, 8'h55);
      bus_wr(2'd1, 8'hAB);
      bus_wr(2'd3, 8'hA0);
      bus_wr(2'd2, 8'h5C);

      // R12: word read advances low then high on the read edge
      live[0] = 16'h3C96;
      bus_rd(2'd0, "R12");
      bus_rd(2'd3);
      bus_rd(2'd0, "R12");

      // R6/R7: latch, repeated latch ignored, then live again
      live[0] = 16'hBEEF;
      bus_wr(2'd3, 8'h00);
      live[0] = 16'h1111;
      bus_rd(2'd0, "R6");
      live[0] = 16'h2222;
      bus_wr(2'd3, 8'h00);
      bus_rd(2'd0, "R7");
      bus_rd(2'd0, "R6");
      bus_rd(2'd0, "R6");

      // R8/R9: combined read-back on channel 0
      m_out[0] = 1; m_nul[0] = 0; live[0] = 16'h7788;
      bus_wr(2'd3, 8'hC2);
      m_out[0] = 0; m_nul[0] = 1; live[0] = 16'h0000;
      bus_rd(2'd0, "R9");
      bus_rd(2'd0, "R8");
      bus_rd(2'd0, "R8");

      // R10: status only on channel 2, second status request ignored
      m_out[2] = 1; m_nul[2] = 1; live[2] = 16'h4321;
      bus_wr(2'd3, 8'hE8);
      m_out[2] = 0;
      bus_wr(2'd3, 8'hE8);
      bus_rd(2'd2, "R10");
      bus_rd(2'd2, "R5");

      // R8: count latch on channels 1 and 2 with one command
      live[1] = 16'h0F0F; live[2] = 16'hF00F;
      bus_wr(2'd3, 8'hDC);
      live[1] = 16'h1234; live[2] = 16'h5678;
      bus_rd(2'd1, "R8");
      bus_rd(2'd2, "R8");
      bus_rd(2'd2, "R5");

      // R2: reprogramming drops held latch
      bus_wr(2'd3, 8'h40);
      live[1] = 16'h9999;
      bus_wr(2'd3, 8'h74);
      bus_rd(2'd1, "R2");
      bus_rd(2'd1, "R2");

      // Constrained random mix
      for (int n = 0; n < 800; n++) begin
         int op = $urandom_range(0, 9);
         int ch = $urandom_range(0, 2);
         case (op)
            0: bus_wr(2'd3, {2'(ch), 2'($urandom_range(1, 3)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1))});
            1: bus_wr(2'd3, {2'(ch), 6'b000000});
            2: bus_wr(2'd3, {2'b11, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 1'b0});
            3, 4: bus_wr(2'(ch), 8'($urandom_range(0, 255)));
            5, 6, 7: bus_rd(2'(ch));
            8: begin
               live[ch] = 16'($urandom_range(0, 65535));
               m_out[ch] = 1'($urandom_range(0, 1));
               m_nul[ch] = 1'($urandom_range(0, 1));
            end
            default: bus_rd(2'd3);
         endcase
      end

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule